// File: doc/BRIEF.md
# PPS-Aligned Seconds and Ticks Timebase

This block keeps absolute time as a seconds count and a sub-second tick count. The tick count advances once per cycle of a 100 MHz clock. When it reaches the last tick of a second it returns to zero and the seconds count advances. Software stages a new time through a small write-only register set: a target seconds value, a target tick value, a flags word and a commit word.

The write to the commit word decides when the staged time takes effect. A commit with bit 0 set loads the time on the same clock edge. A commit with bit 0 clear arms the block, and the staged time then loads once, on the next qualifying pulse-per-second (PPS) edge. The flags word chooses between two PPS inputs and selects whether the rising or the falling edge qualifies.

The selected PPS input passes through a two-flop synchronizer before edge detection. Each qualifying edge raises a one-cycle event pulse that can drive an interrupt. The current seconds and ticks are always available on separate output ports.

Top module: `pps_timebase`

## Requirements
- R1: While reset is asserted, and immediately after it is released, seconds and ticks read 0, the event pulse is low, no load is armed, and the flags are 0 (falling edge, input A).
- R2: Without a load, ticks advance by one on every clock edge. At TICKS_PER_SEC-1 they return to 0, and on that same edge the seconds count advances by one.
- R3: A write to address 3 with data bit 0 = 1 loads the staged seconds and ticks on that same clock edge, and it cancels any armed load.
- R4: A write to address 3 with data bit 0 = 0 arms the block. The staged time then loads on the clock edge during which the event pulse is high.
- R5: An armed load is applied only once. Later PPS edges do not reload the time.
- R6: Flags bit 0 selects the qualifying PPS edge: 0 = falling, 1 = rising. The other edge raises no event and causes no load.
- R7: Flags bit 1 selects the PPS source: 0 = input A, 1 = input B. Transitions on the unselected input have no effect.
- R8: Take the first clock edge that samples a change of the selected input as edge n. The event pulse is then high only during the cycle that follows edge n+1. An armed load is visible after edge n+2.
- R9: A PPS-aligned load that falls on the rollover edge takes priority: the loaded values appear, not the wrapped ones.
- R10: A qualifying PPS edge with no load armed still pulses the event output and leaves the count undisturbed.
- R11: Address decode: 0 stages seconds, 1 stages ticks, 2 writes flags, 3 commits. A write to addresses 0 to 2 does not disturb the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 seconds, 1 ticks, 2 flags, 3 commit) |
| wr_data | input | DATA_W | Write data |
| pps_a | input | 1 | PPS input A, asynchronous |
| pps_b | input | 1 | PPS input B, asynchronous |
| secs_o | output | SEC_W | Current seconds |
| ticks_o | output | TICK_W | Current ticks within the second |
| pps_evt_o | output | 1 | One-cycle pulse on each qualifying PPS edge |

## Verification
An immediate commit shows its loaded time right after the write edge, so the bench samples at the falling edge that follows the write. A PPS level change driven at a falling edge raises the event after the second rising edge and lands an armed load on the third. The bench therefore checks the event two falling edges after it drives the input, and checks the time one falling edge later. Free-running time is tracked by a bench-side seconds and ticks model that steps once per cycle and is overwritten only where a load is due. The rollover-override case is placed by waiting until the model shows the tick count two short of the load edge.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    // Register addresses; the commit register must be the last one written.
    typedef enum logic [1:0] {
        ADDR_SECS  = 2'd0,
        ADDR_TICKS = 2'd1,
        ADDR_FLAGS = 2'd2,
        ADDR_CMD   = 2'd3
    } reg_addr_e;

    localparam int FLAG_EDGE_BIT = 0;   // 1 = rising edge qualifies
    localparam int FLAG_SRC_BIT  = 1;   // 1 = input B
    localparam int CMD_NOW_BIT   = 0;   // 1 = load immediately
    localparam int FLAG_W        = 2;

endpackage

// File: rtl/ptb_pps_sync.sv
module ptb_pps_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_a_i,
    input  logic pps_b_i,
    input  logic src_sel_i,
    input  logic rise_sel_i,
    output logic evt_o
);
    localparam int LAST_STG = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        pps_sel;
    logic        rise_hit, fall_hit;

    always_comb begin
        pps_sel = src_sel_i ? pps_b_i : pps_a_i;
        st_d = st_q;
        st_d.chain = {st_q.chain[LAST_STG-1:0], pps_sel};
        st_d.prev  = st_q.chain[LAST_STG];
        rise_hit = st_q.chain[LAST_STG] & ~st_q.prev;
        fall_hit = ~st_q.chain[LAST_STG] & st_q.prev;
        evt_o    = rise_sel_i ? rise_hit : fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (!evt_o || (rise_sel_i != $past(rise_sel_i))));

endmodule

// File: rtl/ptb_load_ctrl.sv
module ptb_load_ctrl
    import ptb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEC_W  = 32,
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pps_evt_i,
    output logic [SEC_W-1:0]  stage_secs_o,
    output logic [TICK_W-1:0] stage_ticks_o,
    output logic              src_sel_o,
    output logic              rise_sel_o,
    output logic              load_o
);

    typedef struct packed {
        logic [SEC_W-1:0]  secs;
        logic [TICK_W-1:0] ticks;
        logic [FLAG_W-1:0] flags;
        logic              armed;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        cmd_wr, now_wr, arm_wr;

    always_comb begin
        cmd_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == ADDR_CMD);
        now_wr = cmd_wr && wr_data_i[CMD_NOW_BIT];
        arm_wr = cmd_wr && !wr_data_i[CMD_NOW_BIT];

        st_d = st_q;
        if (wr_en_i) begin
            unique case (reg_addr_e'(wr_addr_i))
                ADDR_SECS:  st_d.secs  = wr_data_i[SEC_W-1:0];
                ADDR_TICKS: st_d.ticks = wr_data_i[TICK_W-1:0];
                ADDR_FLAGS: st_d.flags = wr_data_i[FLAG_W-1:0];
                default:    ;
            endcase
        end

        if (now_wr) begin
            st_d.armed = 1'b0;
        end else if (arm_wr) begin
            st_d.armed = 1'b1;
        end else if (st_q.armed && pps_evt_i) begin
            st_d.armed = 1'b0;
        end

        load_o        = now_wr || (st_q.armed && pps_evt_i);
        stage_secs_o  = st_q.secs;
        stage_ticks_o = st_q.ticks;
        src_sel_o     = st_q.flags[FLAG_SRC_BIT];
        rise_sel_o    = st_q.flags[FLAG_EDGE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && pps_evt_i && !cmd_wr) |=> !st_q.armed);

    // R3
    now_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        now_wr |=> !st_q.armed);

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
    parameter int SEC_W         = 32,
    parameter int TICK_W        = 32,
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SEC_W-1:0]  load_secs_i,
    input  logic [TICK_W-1:0] load_ticks_i,
    output logic [SEC_W-1:0]  secs_o,
    output logic [TICK_W-1:0] ticks_o
);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_SEC - 1);
    localparam logic [TICK_W-1:0] TICK_ONE  = TICK_W'(1);
    localparam logic [SEC_W-1:0]  SEC_ONE   = SEC_W'(1);

    typedef struct packed {
        logic [SEC_W-1:0]  secs;
        logic [TICK_W-1:0] ticks;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.secs  = load_secs_i;
            st_d.ticks = load_ticks_i;
        end else if (st_q.ticks >= LAST_TICK) begin
            st_d.ticks = '0;
            st_d.secs  = st_q.secs + SEC_ONE;
        end else begin
            st_d.ticks = st_q.ticks + TICK_ONE;
        end
        secs_o  = st_q.secs;
        ticks_o = st_q.ticks;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.ticks < LAST_TICK) |=>
        (ticks_o == $past(ticks_o) + TICK_ONE && secs_o == $past(secs_o)));

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.ticks == LAST_TICK) |=>
        (ticks_o == '0 && secs_o == $past(secs_o) + SEC_ONE));

    // R9
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (secs_o == $past(load_secs_i) && ticks_o == $past(load_ticks_i)));

endmodule

// File: rtl/pps_timebase.sv
module pps_timebase #(
    parameter int DATA_W        = 32,
    parameter int SEC_W         = 32,
    parameter int TICK_W        = 32,
    parameter int TICKS_PER_SEC = 100_000_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pps_a,
    input  logic              pps_b,
    output logic [SEC_W-1:0]  secs_o,
    output logic [TICK_W-1:0] ticks_o,
    output logic              pps_evt_o
);

    logic [SEC_W-1:0]  stage_secs;
    logic [TICK_W-1:0] stage_ticks;
    logic              src_sel, rise_sel, load;

    ptb_pps_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pps_a_i    (pps_a),
        .pps_b_i    (pps_b),
        .src_sel_i  (src_sel),
        .rise_sel_i (rise_sel),
        .evt_o      (pps_evt_o)
    );

    ptb_load_ctrl #(
        .DATA_W (DATA_W),
        .SEC_W  (SEC_W),
        .TICK_W (TICK_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .pps_evt_i     (pps_evt_o),
        .stage_secs_o  (stage_secs),
        .stage_ticks_o (stage_ticks),
        .src_sel_o     (src_sel),
        .rise_sel_o    (rise_sel),
        .load_o        (load)
    );

    ptb_counter #(
        .SEC_W         (SEC_W),
        .TICK_W        (TICK_W),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .load_secs_i  (stage_secs),
        .load_ticks_i (stage_ticks),
        .secs_o       (secs_o),
        .ticks_o      (ticks_o)
    );

endmodule

// File: tb/pps_timebase_test.sv
module pps_timebase_test;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 20;

    typedef struct packed {
        logic [31:0] secs;
        logic [31:0] ticks;
        logic [31:0] wait_n;
        logic [31:0] exp_s;
        logic [31:0] exp_t;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'd5,           32'd0,  32'd3,  32'd5,           32'd3},
        '{32'd100,         32'd18, 32'd3,  32'd101,         32'd1},
        '{32'd7,           32'd19, 32'd1,  32'd8,           32'd0},
        '{32'hFFFF_FFFF,   32'd10, 32'd0,  32'hFFFF_FFFF,   32'd10},
        '{32'd42,          32'd0,  32'd45, 32'd44,          32'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pps_a = 1'b0;
    logic        pps_b = 1'b0;
    logic [31:0] secs_o, ticks_o;
    logic        pps_evt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [31:0] exp_s = 0, exp_t = 0;

    pps_timebase #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pps_a(pps_a), .pps_b(pps_b),
        .secs_o(secs_o), .ticks_o(ticks_o), .pps_evt_o(pps_evt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(negedge clk);
        if (exp_t == TPS - 1) begin
            exp_t = 0;
            exp_s = exp_s + 1;
        end else begin
            exp_t = exp_t + 1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk_time(input string req, input logic [31:0] es, input logic [31:0] et);
        n_checks++;
        if (secs_o !== es || ticks_o !== et) begin
            n_fail++;
            $display("FAIL %s: time %0d.%0d expected %0d.%0d", req, secs_o, ticks_o, es, et);
        end
    endtask

    task automatic chk_evt(input string req, input logic e);
        n_checks++;
        if (pps_evt_o !== e) begin
            n_fail++;
            $display("FAIL %s: pps_evt_o %b expected %b", req, pps_evt_o, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run incomplete, expected finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_time("R1", 0, 0);
        chk_evt("R1", 1'b0);
        rst_n = 1'b1;
        exp_s = 0; exp_t = 0;
        chk_time("R1", 0, 0);
        step();
        chk_time("R2", exp_s, exp_t);

        // R3 R2 R11: immediate loads from the table
        for (int i = 0; i < 5; i++) begin
            wr(2'd0, VECS[i].secs);
            wr(2'd1, VECS[i].ticks);
            chk_time("R11", exp_s, exp_t);
            wr(2'd3, 32'd1);
            exp_s = VECS[i].secs; exp_t = VECS[i].ticks;
            chk_time("R3", VECS[i].secs, VECS[i].ticks);
            for (int w = 0; w < int'(VECS[i].wait_n); w++) step();
            chk_time("R2", VECS[i].exp_s, VECS[i].exp_t);
        end

        // Known base
        wr(2'd0, 32'd10); wr(2'd1, 32'd0); wr(2'd3, 32'd1);
        exp_s = 10; exp_t = 0;

        // R4 R6: arm, falling edge on input A
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd200); wr(2'd1, 32'd3); wr(2'd3, 32'd0);
        chk_time("R11", exp_s, exp_t);
        pps_a = 1'b1;
        step(); step();
        chk_evt("R6", 1'b0);
        step();
        chk_time("R6", exp_s, exp_t);
        pps_a = 1'b0;
        step(); step();
        chk_evt("R8", 1'b1);
        chk_time("R8", exp_s, exp_t);
        step();
        exp_s = 200; exp_t = 3;
        chk_time("R4", 200, 3);
        chk_evt("R8", 1'b0);

        // R5 R10: later falling edge, nothing armed
        pps_a = 1'b1; step(); step(); step();
        pps_a = 1'b0; step(); step();
        chk_evt("R10", 1'b1);
        step();
        chk_time("R5", exp_s, exp_t);

        // R7: source B, rising edge
        wr(2'd2, 32'd3);
        wr(2'd0, 32'd300); wr(2'd1, 32'd7); wr(2'd3, 32'd0);
        pps_a = 1'b1; step(); step();
        chk_evt("R7", 1'b0);
        step();
        chk_time("R7", exp_s, exp_t);
        pps_a = 1'b0; step(); step(); step();
        pps_b = 1'b1; step(); step();
        chk_evt("R7", 1'b1);
        step();
        exp_s = 300; exp_t = 7;
        chk_time("R7", 300, 7);

        // R9: PPS load lands on the rollover edge
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd900); wr(2'd1, 32'd5); wr(2'd3, 32'd0);
        step(); step(); step();
        while (exp_t != TPS - 3) step();
        pps_a = 1'b1;
        step(); step();
        chk_time("R9", exp_s, TPS - 1);
        chk_evt("R9", 1'b1);
        step();
        exp_s = 900; exp_t = 5;
        chk_time("R9", 900, 5);

        // R3: immediate commit cancels an armed load
        wr(2'd0, 32'd11); wr(2'd1, 32'd0); wr(2'd3, 32'd0);
        wr(2'd0, 32'd12); wr(2'd1, 32'd4); wr(2'd3, 32'd1);
        exp_s = 12; exp_t = 4;
        chk_time("R3", 12, 4);
        pps_a = 1'b0; step(); step(); step();
        pps_a = 1'b1; step(); step();
        chk_evt("R3", 1'b1);
        step();
        chk_time("R3", exp_s, exp_t);

        finish_run();
    end

endmodule